// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Pulse Encoding and Break

This block serialises one character at a time onto a single transmit line. A load strobe hands it a data word. The block then sends a low start bit, eight or nine data bits with the least significant bit first, and a high stop bit. Each bit lasts sixteen pulses of an external baud enable, so the block runs from an oversampling enable that is generated outside it. The block can also send a break: a run of space-level bit times, followed by one mark-level bit time. The break comes in a short form and an extended form.

The line can be encoded in two ways. In NRZ mode the line holds the bit level. In pulse mode a zero is a short pulse in the middle of the bit, and a one leaves the line at its idle level. Both modes have a polarity inversion control. For shared-wire operation, an output enable follows a direction input when single-wire mode is on, and stays asserted when it is off. A busy flag tells the host when a new strobe will be accepted.

Top module: `sertx_top`

## Requirements
- R1: After reset, busy is 0 and the line is idle. The idle level is 1 for NRZ with normal polarity, 0 for NRZ inverted, 0 for pulse mode with normal polarity, and 1 for pulse mode inverted.
- R2: Frame order in 8-bit mode (nine_bit=0) is: a start bit of 0, then load_data[0] through load_data[7], then a stop bit of 1. Each bit lasts 16 baud_tick pulses, with the ticks of a bit counted 0 to 15. In NRZ mode with tx_invert=0, txd equals the bit value.
- R3: With nine_bit=1, load_data[8] is sent after load_data[7] and before the stop bit, so the frame is 11 bits long.
- R4: In NRZ mode with tx_invert=1, every level on txd is the complement of the bit value, and this includes the idle level.
- R5: In pulse mode (pulse_mode=1) with tx_invert=0, a 0 bit drives txd high during ticks 7, 8 and 9 of the bit and low during the rest of the bit. A 1 bit keeps txd low for the whole bit.
- R6: In pulse mode with tx_invert=1, a 0 bit drives txd low during ticks 7 to 9 and high during the rest of the bit. A 1 bit keeps txd high.
- R7: When send_break is accepted with long_break=0, the block sends 10 space bit times (or 11 when nine_bit=1) and then one mark bit time. Busy stays high until that mark bit ends.
- R8: When send_break is accepted with long_break=1, the block sends 13 space bit times (or 14 when nine_bit=1) and then one mark bit time.
- R9: A strobe is accepted only while busy is 0. Busy rises in the cycle after the accepting edge and falls after the last tick of the stop bit or of the closing mark bit. While busy is 1, load and send_break are ignored.
- R10: txd_oe equals drive_out when single_wire=1, and is 1 when single_wire=0.
- R11: The line position advances only on baud_tick. Without ticks, txd and busy hold their values.
- R12: If load and send_break arrive in the same idle cycle, the data frame is sent and the break request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | Enable at 16 times the bit rate |
| load | input | 1 | Start a data frame |
| load_data | input | 9 | Character to send; bit 8 is used only in 9-bit mode |
| send_break | input | 1 | Start a break |
| nine_bit | input | 1 | 1 selects 9 data bits and the longer break of each form |
| long_break | input | 1 | 1 selects the extended break |
| tx_invert | input | 1 | Line polarity inversion |
| pulse_mode | input | 1 | 1 selects mid-bit pulse encoding, 0 selects NRZ |
| single_wire | input | 1 | Shared-wire operation |
| drive_out | input | 1 | Direction of txd in shared-wire operation: 1 means drive |
| txd | output | 1 | Serial line |
| txd_oe | output | 1 | Output enable for txd |
| busy | output | 1 | A frame or break is in progress |

## Verification
Suppose the tick counter or the shift image goes wrong. In pulse mode a bad tick count moves the pulse off ticks 7 to 9 within one bit time. In NRZ mode a bad shift image gives a wrong level on txd at the next bit boundary, which is at most 16 baud ticks later. A bad bit countdown changes the frame or break length, and the busy flag then falls on the wrong tick at the end of the frame. The bench compares txd, busy and txd_oe against its model on every clock, so each of these faults is reported in the cycle where it first shows at a port.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    // Source of a new transmission accepted in an idle cycle
    typedef enum logic [1:0] {
        KICK_NONE  = 2'd0,
        KICK_FRAME = 2'd1,
        KICK_BREAK = 2'd2
    } kick_e;

    // Space bit times of the short break in 8-bit mode
    localparam int BRK_BASE  = 10;
    // Extra space bit times of the extended break
    localparam int BRK_EXTRA = 3;
endpackage

// File: rtl/sertx_tickctr.sv
module sertx_tickctr #(
    parameter int TPB = 16,
    localparam int CW = $clog2(TPB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          run,
    input  logic          baud_tick,
    output logic [CW-1:0] tick_cnt,
    output logic          bit_end
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic last_tick;

    always_comb begin
        st_d      = st_q;
        last_tick = (st_q.cnt == CW'(TPB - 1));
        bit_end   = 1'b0;
        if (clear) begin
            st_d.cnt = '0;
        end else if (run && baud_tick) begin
            bit_end  = last_tick;
            st_d.cnt = last_tick ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_cnt = st_q.cnt;
endmodule

// File: rtl/sertx_seq.sv
module sertx_seq
    import sertx_pkg::*;
#(
    parameter int DW = 9,
    localparam int SHW = BRK_BASE + 1 + BRK_EXTRA + 1,
    localparam int LW  = $clog2(SHW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          send_break,
    input  logic          nine_bit,
    input  logic          long_break,
    input  logic          bit_end,
    output logic          kick,
    output logic          busy,
    output logic          cur_bit
);
    typedef struct packed {
        logic [SHW-1:0] shreg;
        logic [LW-1:0]  left;
    } st_t;

    st_t   st_d, st_q;
    kick_e kind;

    always_comb begin
        int            nbits;
        int            brk;
        logic [DW-1:0] data_m;

        st_d   = st_q;
        nbits  = nine_bit ? DW : DW - 1;
        brk    = BRK_BASE + (nine_bit ? 1 : 0) + (long_break ? BRK_EXTRA : 0);
        data_m = load_data;
        if (!nine_bit) data_m[DW-1] = 1'b0;

        kind = KICK_NONE;
        if (st_q.left == '0) begin
            if (load)            kind = KICK_FRAME;
            else if (send_break) kind = KICK_BREAK;
        end

        unique case (kind)
            KICK_FRAME: begin
                st_d.shreg = ({SHW{1'b1}} << (nbits + 1)) | (SHW'(data_m) << 1);
                st_d.left  = LW'(nbits + 2);
            end
            KICK_BREAK: begin
                st_d.shreg = {SHW{1'b1}} << brk;
                st_d.left  = LW'(brk + 1);
            end
            default: begin
                if (bit_end && st_q.left != '0) begin
                    st_d.shreg = {1'b1, st_q.shreg[SHW-1:1]};
                    st_d.left  = st_q.left - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.shreg <= '1;
            st_q.left  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign kick    = (kind != KICK_NONE);
    assign busy    = (st_q.left != '0);
    assign cur_bit = busy ? st_q.shreg[0] : 1'b1;
endmodule

// File: rtl/sertx_enc.sv
module sertx_enc #(
    parameter int TPB    = 16,
    parameter int PSTART = 7,
    parameter int PLEN   = 3,
    localparam int CW = $clog2(TPB)
) (
    input  logic          bit_val,
    input  logic [CW-1:0] tick_cnt,
    input  logic          tx_invert,
    input  logic          pulse_mode,
    input  logic          single_wire,
    input  logic          drive_out,
    output logic          txd,
    output logic          txd_oe
);
    logic in_window;

    always_comb begin
        in_window = (int'(tick_cnt) >= PSTART) && (int'(tick_cnt) < PSTART + PLEN);
        if (pulse_mode) txd = (!bit_val && in_window) ? !tx_invert : tx_invert;
        else            txd = bit_val ^ tx_invert;
        txd_oe = single_wire ? drive_out : 1'b1;
    end
endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
    parameter int DW     = 9,
    parameter int TPB    = 16,
    parameter int PSTART = 7,
    parameter int PLEN   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          send_break,
    input  logic          nine_bit,
    input  logic          long_break,
    input  logic          tx_invert,
    input  logic          pulse_mode,
    input  logic          single_wire,
    input  logic          drive_out,
    output logic          txd,
    output logic          txd_oe,
    output logic          busy
);
    localparam int CW = $clog2(TPB);

    logic          kick;
    logic          bit_end;
    logic [CW-1:0] tick_cnt;
    logic          cur_bit;

    sertx_tickctr #(.TPB(TPB)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (kick),
        .run      (busy),
        .baud_tick(baud_tick),
        .tick_cnt (tick_cnt),
        .bit_end  (bit_end)
    );

    sertx_seq #(.DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (load_data),
        .send_break(send_break),
        .nine_bit  (nine_bit),
        .long_break(long_break),
        .bit_end   (bit_end),
        .kick      (kick),
        .busy      (busy),
        .cur_bit   (cur_bit)
    );

    sertx_enc #(.TPB(TPB), .PSTART(PSTART), .PLEN(PLEN)) u_enc (
        .bit_val    (cur_bit),
        .tick_cnt   (tick_cnt),
        .tx_invert  (tx_invert),
        .pulse_mode (pulse_mode),
        .single_wire(single_wire),
        .drive_out  (drive_out),
        .txd        (txd),
        .txd_oe     (txd_oe)
    );
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk #(
    parameter int CW     = 4,
    parameter int PSTART = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          baud_tick,
    input logic          load,
    input logic          send_break,
    input logic          tx_invert,
    input logic          pulse_mode,
    input logic          single_wire,
    input logic          drive_out,
    input logic          txd,
    input logic          txd_oe,
    input logic          busy,
    input logic [CW-1:0] tick_cnt,
    input logic          cur_bit
);
    p_idle_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !pulse_mode) |-> (txd == !tx_invert));

    p_start_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !busy) |=> (busy && !cur_bit && tick_cnt == '0));

    p_pulse_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pulse_mode && !tx_invert && int'(tick_cnt) < PSTART) |-> !txd);

    p_break_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (send_break && !load && !busy) |=> (busy && !cur_bit));

    p_oe_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        txd_oe == (single_wire ? drive_out : 1'b1));

    p_hold_no_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !baud_tick) |=> ($stable(cur_bit) && $stable(tick_cnt) && busy));
endmodule

bind sertx_top sertx_chk #(.CW(CW), .PSTART(PSTART)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .load       (load),
    .send_break (send_break),
    .tx_invert  (tx_invert),
    .pulse_mode (pulse_mode),
    .single_wire(single_wire),
    .drive_out  (drive_out),
    .txd        (txd),
    .txd_oe     (txd_oe),
    .busy       (busy),
    .tick_cnt   (tick_cnt),
    .cur_bit    (cur_bit)
);

// File: tb/sertx_top_test.sv
`timescale 1ns/1ps
module sertx_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       load = 1'b0;
    logic [8:0] load_data = '0;
    logic       send_break = 1'b0;
    logic       nine_bit = 1'b0;
    logic       long_break = 1'b0;
    logic       tx_invert = 1'b0;
    logic       pulse_mode = 1'b0;
    logic       single_wire = 1'b0;
    logic       drive_out = 1'b0;
    logic       txd, txd_oe, busy;

    int    checks = 0;
    int    errors = 0;
    string phase = "R1";
    bit    tick_on = 1'b1;
    int    tick_div = 0;
    bit    mq[$];
    int    mt = 0;

    always #10 clk = ~clk;

    sertx_top uut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .load(load),
        .load_data(load_data), .send_break(send_break), .nine_bit(nine_bit),
        .long_break(long_break), .tx_invert(tx_invert), .pulse_mode(pulse_mode),
        .single_wire(single_wire), .drive_out(drive_out),
        .txd(txd), .txd_oe(txd_oe), .busy(busy)
    );

    function automatic logic line_of(input logic b, input int t);
        if (!pulse_mode) return b ^ tx_invert;
        if (!b && t >= 7 && t <= 9) return !tx_invert;
        return tx_invert;
    endfunction

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic cyc();
        baud_tick = tick_on && (tick_div == 0);
        tick_div = (tick_div + 1) % 2;
        @(posedge clk);
        if (!rst_n) begin
            mq.delete();
            mt = 0;
        end else if (mq.size() == 0) begin
            if (load) begin
                mt = 0;
                mq.push_back(1'b0);
                for (int i = 0; i < (nine_bit ? 9 : 8); i++) mq.push_back(load_data[i]);
                mq.push_back(1'b1);
            end else if (send_break) begin
                mt = 0;
                for (int i = 0; i < 10 + (nine_bit ? 1 : 0) + (long_break ? 3 : 0); i++)
                    mq.push_back(1'b0);
                mq.push_back(1'b1);
            end
        end else if (baud_tick) begin
            if (mt == 15) begin
                mq.delete(0);
                mt = 0;
            end else begin
                mt++;
            end
        end
        @(negedge clk);
        if (rst_n) begin
            check(phase, "txd", txd, line_of(mq.size() != 0 ? mq[0] : 1'b1, mt));
            check(phase, "busy", busy, mq.size() != 0);
            check(phase, "txd_oe", txd_oe, single_wire ? drive_out : 1'b1);
        end
    endtask

    task automatic run_idle();
        int guard = 0;
        while (mq.size() != 0 && guard < 5000) begin
            cyc();
            guard++;
        end
        repeat (4) cyc();
    endtask

    task automatic send(input logic [8:0] d);
        load_data = d;
        load = 1'b1;
        cyc();
        load = 1'b0;
        run_idle();
    endtask

    task automatic brk();
        send_break = 1'b1;
        cyc();
        send_break = 1'b0;
        run_idle();
    endtask

    initial begin
        #3_000_000;
        errors++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) cyc();
        rst_n = 1'b1;
        @(negedge clk);
        phase = "R1";
        check("R1", "busy after reset", busy, 1'b0);
        check("R1", "idle txd after reset", txd, 1'b1);
        check("R1", "txd_oe after reset", txd_oe, 1'b1);
        repeat (3) cyc();

        phase = "R2"; send(9'h0A5); send(9'h001);
        phase = "R3"; nine_bit = 1'b1; send(9'h13C); send(9'h0FF); nine_bit = 1'b0;
        phase = "R4"; tx_invert = 1'b1; repeat (3) cyc(); send(9'h05A); tx_invert = 1'b0;
        phase = "R5"; pulse_mode = 1'b1; repeat (3) cyc(); send(9'h096);
        phase = "R6"; tx_invert = 1'b1; nine_bit = 1'b1; send(9'h069);
        pulse_mode = 1'b0; tx_invert = 1'b0; nine_bit = 1'b0;
        phase = "R7"; brk(); nine_bit = 1'b1; brk(); nine_bit = 1'b0;
        phase = "R8"; long_break = 1'b1; brk(); nine_bit = 1'b1; brk();
        nine_bit = 1'b0; long_break = 1'b0;

        phase = "R9";
        load_data = 9'h00F; load = 1'b1; cyc(); load = 1'b0;
        repeat (40) cyc();
        load_data = 9'h0F0; load = 1'b1; cyc(); load = 1'b0;
        repeat (30) cyc();
        send_break = 1'b1; cyc(); send_break = 1'b0;
        run_idle();

        phase = "R11";
        load_data = 9'h0C3; load = 1'b1; cyc(); load = 1'b0;
        repeat (50) cyc();
        tick_on = 1'b0;
        repeat (40) cyc();
        tick_on = 1'b1;
        run_idle();

        phase = "R12";
        load_data = 9'h033; load = 1'b1; send_break = 1'b1; cyc();
        load = 1'b0; send_break = 1'b0;
        run_idle();

        phase = "R10";
        single_wire = 1'b1; drive_out = 1'b0; cyc();
        check("R10", "oe released", txd_oe, 1'b0);
        drive_out = 1'b1; cyc();
        check("R10", "oe driven", txd_oe, 1'b1);
        single_wire = 1'b0; drive_out = 1'b0; cyc();
        check("R10", "oe outside single-wire", txd_oe, 1'b1);
        single_wire = 1'b1; send(9'h055);
        single_wire = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule